// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a physical address by reading two entries from a page table held in memory. It forms the first entry's address from a directory base input, which holds a separate value for each address space, and from the top ten bits of the linear address. It takes the frame of a page table from that entry and reads the second entry. It then joins the page frame from the second entry with the 12-bit page offset. Pages and tables are 4 KB in size and sit on 4 KB boundaries. Each table level holds 1024 entries of 4 bytes.

A requester hands over one linear address at a time through a valid/ready pair and gets back a one-cycle response that carries either a physical address or a fault. The walk stops with a fault when the present bit of either entry is clear. A dedicated register then captures the faulting linear address, so that software can load the page and retry. When paging is switched off, the address comes back unchanged and no memory is read.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, `rsp_valid_o` and `mem_req_valid_o` are 0, and `fault_laddr_o` is 0.
- R2: With `paging_en_i` low when a request is accepted, the response carries `rsp_paddr_o` equal to the linear address and `rsp_fault_o` low, and no memory read is issued.
- R3: The first memory read of a walk uses the address {`dir_base_i`[31:12], laddr[31:22], 2'b00}. Bits 11:0 of `dir_base_i` are ignored.
- R4: The second memory read uses the address {directory entry[31:12], laddr[21:12], 2'b00}.
- R5: When both entries have bit 0 (present) set, the response carries `rsp_paddr_o` = {table entry[31:12], laddr[11:0]} with `rsp_fault_o` low.
- R6: A directory entry with bit 0 clear ends the walk with `rsp_fault_o` high, and the table entry is not read.
- R7: A table entry with bit 0 clear ends the walk with `rsp_fault_o` high.
- R8: `fault_laddr_o` takes the linear address of each faulting walk by the response cycle. It changes at no other time.
- R9: Only one walk is in flight at a time: `req_ready_o` is low from acceptance through the response cycle, and `rsp_valid_o` is high for exactly one cycle per request.
- R10: While `mem_req_ready_i` is low, `mem_req_valid_o` stays high and `mem_req_addr_o` stays stable.
- R11: Entry bits 11:1 have no effect on the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| paging_en_i | input | 1 | Translation enable, sampled when a request is accepted |
| dir_base_i | input | 32 | Physical base of the current page directory |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_laddr_i | input | 32 | Linear address to translate |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Response is a page fault |
| rsp_paddr_o | output | 32 | Translated physical address |
| fault_laddr_o | output | 32 | Linear address of the most recent fault |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |

## Verification
The checker assumes a memory that returns exactly one response for each accepted read, no earlier than the cycle after acceptance. It also assumes that `dir_base_i` stays steady for the length of a walk. The bench memory model meets both conditions: it registers each accepted request and drives the data one cycle later, and the bench changes the directory base only between walks while the walker is idle. Pseudo-random backpressure on the read-ready input exercises the hold rule of R10 without breaking the one-response-per-read rule.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  // byte address of an entry = base + index * 4
  localparam int unsigned ENTRY_SHIFT = 2;
  localparam int unsigned PRESENT_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_READ,
    ST_TBL_READ,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_fire_i,
  input  logic        paging_en_i,
  input  logic        mem_req_ready_i,
  input  logic        mem_rsp_valid_i,
  input  logic        entry_present_i,
  output walk_state_e state_o,
  output logic        mem_req_valid_o,
  output logic        ld_table_o,
  output logic        ld_frame_o,
  output logic        fault_set_o,
  output logic        pass_o
);
  walk_state_e state_q, state_d;
  logic        sent_q, sent_d;
  logic        walking, rsp_take;

  assign walking         = (state_q == ST_DIR_READ) || (state_q == ST_TBL_READ);
  assign mem_req_valid_o = walking && !sent_q;
  // data only counts once the read has been handed to memory
  assign rsp_take        = walking && sent_q && mem_rsp_valid_i;

  assign ld_table_o  = rsp_take && (state_q == ST_DIR_READ) && entry_present_i;
  assign ld_frame_o  = rsp_take && (state_q == ST_TBL_READ) && entry_present_i;
  assign fault_set_o = rsp_take && !entry_present_i;
  assign pass_o      = (state_q == ST_IDLE) && req_fire_i && !paging_en_i;
  assign state_o     = state_q;

  always_comb begin
    sent_d = sent_q;
    if (mem_req_valid_o && mem_req_ready_i) sent_d = 1'b1;
    else if (rsp_take)                      sent_d = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (req_fire_i) state_d = paging_en_i ? ST_DIR_READ : ST_DONE;
      ST_DIR_READ:
        if (rsp_take) state_d = entry_present_i ? ST_TBL_READ : ST_FAULT;
      ST_TBL_READ:
        if (rsp_take) state_d = entry_present_i ? ST_DONE : ST_FAULT;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_d;
    end
  end
endmodule

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
  import pt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_fire_i,
  input  logic [ADDR_W-1:0]          req_laddr_i,
  input  logic [ADDR_W-OFF_W-1:0]    dir_frame_i,
  input  logic [ADDR_W-OFF_W-1:0]    entry_frame_i,
  input  logic                       sel_dir_i,
  input  logic                       ld_table_i,
  input  logic                       ld_frame_i,
  input  logic                       pass_i,
  output logic [ADDR_W-1:0]          laddr_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [ADDR_W-1:0]          paddr_o
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  laddr_q, paddr_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [IDX_W-1:0]   dir_idx, tbl_idx;
  logic [OFF_W-1:0]   page_off;
  logic [FRAME_W-1:0] base_sel;
  logic [IDX_W-1:0]   idx_sel;

  assign dir_idx  = laddr_q[ADDR_W-1 -: IDX_W];
  assign tbl_idx  = laddr_q[OFF_W +: IDX_W];
  assign page_off = laddr_q[OFF_W-1:0];

  assign base_sel   = sel_dir_i ? dir_frame_i : tbl_frame_q;
  assign idx_sel    = sel_dir_i ? dir_idx : tbl_idx;
  assign mem_addr_o = {base_sel, idx_sel, {ENTRY_SHIFT{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      laddr_q     <= '0;
      tbl_frame_q <= '0;
      paddr_q     <= '0;
    end else begin
      if (req_fire_i) laddr_q     <= req_laddr_i;
      if (ld_table_i) tbl_frame_q <= entry_frame_i;
      if (pass_i)          paddr_q <= req_laddr_i;
      else if (ld_frame_i) paddr_q <= {entry_frame_i, page_off};
    end
  end

  assign laddr_o = laddr_q;
  assign paddr_o = paddr_q;
endmodule

// File: rtl/pt_walk_fault.sv
module pt_walk_fault #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_set_i,
  input  logic [ADDR_W-1:0] laddr_i,
  output logic [ADDR_W-1:0] fault_laddr_o
);
  logic [ADDR_W-1:0] fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fault_q <= '0;
    else if (fault_set_i) fault_q <= laddr_i;
  end

  assign fault_laddr_o = fault_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = IDX_W + ENTRY_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              paging_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_laddr_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [ADDR_W-1:0] fault_laddr_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  walk_state_e       state;
  logic              req_fire, ld_table, ld_frame, fault_set, pass;
  logic [ADDR_W-1:0] laddr;
  logic              unused_low_bits;

  // attribute bits and base offset bits carry no meaning here
  assign unused_low_bits = ^{mem_rsp_data_i[OFF_W-1:PRESENT_BIT+1], dir_base_i[OFF_W-1:0]};

  assign req_ready_o = (state == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  assign rsp_valid_o = (state == ST_DONE) || (state == ST_FAULT);
  assign rsp_fault_o = (state == ST_FAULT);

  pt_walk_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_fire_i      (req_fire),
    .paging_en_i     (paging_en_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .entry_present_i (mem_rsp_data_i[PRESENT_BIT]),
    .state_o         (state),
    .mem_req_valid_o (mem_req_valid_o),
    .ld_table_o      (ld_table),
    .ld_frame_o      (ld_frame),
    .fault_set_o     (fault_set),
    .pass_o          (pass)
  );

  pt_walk_addr #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_addr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_fire_i    (req_fire),
    .req_laddr_i   (req_laddr_i),
    .dir_frame_i   (dir_base_i[ADDR_W-1:OFF_W]),
    .entry_frame_i (mem_rsp_data_i[ADDR_W-1:OFF_W]),
    .sel_dir_i     (state == ST_DIR_READ),
    .ld_table_i    (ld_table),
    .ld_frame_i    (ld_frame),
    .pass_i        (pass),
    .laddr_o       (laddr),
    .mem_addr_o    (mem_req_addr_o),
    .paddr_o       (rsp_paddr_o)
  );

  pt_walk_fault #(
    .ADDR_W (ADDR_W)
  ) u_fault (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_set_i   (fault_set),
    .laddr_i       (laddr),
    .fault_laddr_o (fault_laddr_o)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [ADDR_W-1:0] fault_laddr_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o
);
  assert_idle_no_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);

  assert_entry_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));

  assert_fault_only_on_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fault_laddr_o) |-> (rsp_valid_o && rsp_fault_o));

  assert_busy_during_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_rsp_single_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_fault_o     (rsp_fault_o),
  .fault_laddr_o   (fault_laddr_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  localparam logic [31:0] BASE_A = 32'h0001_0ABC;  // low bits must be ignored (R3)
  localparam logic [31:0] BASE_B = 32'h0002_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        paging_en_i = 1'b0;
  logic [31:0] dir_base_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_laddr_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [31:0] rsp_paddr_o, fault_laddr_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b1;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  int          n_chk = 0, n_fail = 0, cyc = 0, req_cnt = 0, stall_cnt = 0;
  logic        stall_en = 1'b0;
  logic [31:0] cur_la = '0, cur_base = '0, last_fault = '0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  always #10 clk_i = ~clk_i;

  pt_walker dut_i (.*);

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory image: two directories, 1024 tables at frames 0x40000..0x403ff
  function automatic logic [31:0] mem_read(input logic [31:0] a);
    logic [19:0] p;
    logic [9:0]  d, t;
    logic        pr;
    p = a[31:12];
    t = a[11:2];
    if (p == BASE_A[31:12] || p == BASE_B[31:12]) begin
      d  = t;
      pr = ((int'(d) % 5) != 3);
      return {20'h40000 + {10'd0, (p == BASE_B[31:12]) ? (d ^ 10'h3ff) : d}, 1'b1, d, pr};
    end else if (p[19:10] == 10'h100) begin
      d  = p[9:0];
      pr = (((int'(d) + int'(t)) % 7) != 6);
      return {~{d, t}, t[0], d, pr};
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] dir_addr(input logic [31:0] base, input logic [31:0] la);
    return {base[31:12], la[31:22], 2'b00};
  endfunction

  // memory model: one response, one cycle after each accepted read
  always @(posedge clk_i) begin
    logic [31:0] exp_a, dv;
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
    if (rst_ni) begin
      if (prev_wait)
        check(mem_req_valid_o && mem_req_addr_o == prev_addr, "R10", mem_req_addr_o, prev_addr);
      prev_wait = mem_req_valid_o && !mem_req_ready_i;
      prev_addr = mem_req_addr_o;
      mem_rsp_valid_i <= 1'b0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (req_cnt == 0) begin
          exp_a = dir_addr(cur_base, cur_la);
          check(mem_req_addr_o == exp_a, "R3", mem_req_addr_o, exp_a);
        end else begin
          dv    = mem_read(dir_addr(cur_base, cur_la));
          exp_a = {dv[31:12], cur_la[21:12], 2'b00};
          check(mem_req_addr_o == exp_a, "R4", mem_req_addr_o, exp_a);
        end
        req_cnt++;
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= mem_read(mem_req_addr_o);
      end
      stall_cnt++;
      mem_req_ready_i <= stall_en ? (((stall_cnt * 7) % 5) > 1) : 1'b1;
    end
  end

  task automatic run_walk(input logic [31:0] la, input logic [31:0] base, input logic pg);
    logic [31:0] pde, pte, exp_pa;
    logic        exp_flt;
    int          exp_cnt, n;
    string       tag;
    exp_flt = 1'b0;
    exp_pa  = la;
    exp_cnt = 0;
    tag     = "R2";
    if (pg) begin
      pde     = mem_read(dir_addr(base, la));
      exp_cnt = 1;
      tag     = "R6";
      if (!pde[0]) exp_flt = 1'b1;
      else begin
        pte     = mem_read({pde[31:12], la[21:12], 2'b00});
        exp_cnt = 2;
        tag     = "R7";
        if (!pte[0]) exp_flt = 1'b1;
        else begin
          exp_pa = {pte[31:12], la[11:0]};
          tag    = "R5/R11";
        end
      end
    end
    @(negedge clk_i);
    cur_la = la; cur_base = base; req_cnt = 0;
    dir_base_i = base; paging_en_i = pg; req_laddr_i = la; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 0;
    if (!rsp_valid_o) check(!req_ready_o, "R9", {31'd0, req_ready_o}, 32'd0);
    while (!rsp_valid_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check(rsp_fault_o == exp_flt, tag, {31'd0, rsp_fault_o}, {31'd0, exp_flt});
    if (exp_flt) begin
      check(fault_laddr_o == la, "R8", fault_laddr_o, la);
      last_fault = la;
    end else begin
      check(rsp_paddr_o == exp_pa, tag, rsp_paddr_o, exp_pa);
      check(fault_laddr_o == last_fault, "R8", fault_laddr_o, last_fault);
    end
    check(req_cnt == exp_cnt, exp_cnt == 1 ? "R6" : "R2", req_cnt, exp_cnt);
    @(negedge clk_i);
    check(!rsp_valid_o && req_ready_o, "R9", {30'd0, rsp_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R1",
          {29'd0, req_ready_o, rsp_valid_o, mem_req_valid_o}, 32'd4);
    check(fault_laddr_o == 32'd0, "R1", fault_laddr_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(req_ready_o && !mem_req_valid_o, "R1", {31'd0, req_ready_o}, 32'd1);

    // R2: pass-through with paging off
    run_walk(32'hDEAD_BEEF, BASE_A, 1'b0);
    run_walk(32'h0000_0000, BASE_A, 1'b0);
    run_walk(32'hFFFF_FFFF, BASE_B, 1'b0);

    // every directory slot of space A, mixed table index and offset
    for (int d = 0; d < 1024; d++) begin
      stall_en = (d >= 512);  // R10 backpressure in second half
      run_walk({d[9:0], 10'((d * 37 + 5) % 1024), 12'((d * 13) % 4096)}, BASE_A, 1'b1);
    end

    // every table slot behind directory slot 1 of space B
    for (int t = 0; t < 1024; t++) begin
      stall_en = t[0];
      run_walk({10'd1, t[9:0], 12'(4095 - t)}, BASE_B, 1'b1);
    end

    // R2 after faults: pass-through leaves fault register alone (R8)
    run_walk(32'h0123_4567, BASE_B, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule